// File: doc/BRIEF.md
# TDM Frame Splitter with Auxiliary I2S Output

This block takes the serial TDM stream that a host DSP sends to a codec and splits each 256-bit frame. The frame holds eight 32-bit slots in the order left 1, left 2, left 3, left 4, then right 1, right 2, right 3, right 4. Six of those slots feed three internal stereo DAC pairs. They are presented in parallel, all at once, with a single-cycle valid strobe when the frame ends. The fourth stereo pair is not used on chip. It is sent out again as a standard I2S stream with 32 bits per channel, for an external DAC.

All logic runs on one system clock. The serial clocks are generated elsewhere and arrive as one-cycle enables. `tdm_bit_en_i` marks a rising edge of the TDM bit clock. `aux_bit_en_i` marks a falling edge of the auxiliary bit clock. Together with the auxiliary LR clock level, these enables decide every update. A frame-sync pulse is sampled on the last bit of each frame, so the next TDM bit is the MSB of slot 0. When a sync pulse arrives at any other bit position, the block raises a sticky flag and realigns to that pulse.

Top module: `tdm_frame_splitter`

## Requirements
- R1: While reset is asserted and right after it, `dac_left_o`, `dac_right_o`, `dac_valid_o`, `misalign_o` and `aux_sd_o` are all zero.
- R2: Slot k of a frame (k = 0..7, first received is 0) is mapped as follows. Slots 0..2 go to lanes 0..2 of `dac_left_o`, and slots 4..6 go to lanes 0..2 of `dac_right_o`. Lane g occupies bits [24g+23:24g].
- R3: Each slot is received MSB first. A lane carries bits 31..8 of its slot, and the low 8 bits of the internal slots have no effect on any DAC lane.
- R4: A TDM bit is taken only on a cycle with `tdm_bit_en_i` high. A tick with `tdm_fs_i` high is the last bit of a frame, and the following tick is the MSB of slot 0. `dac_valid_o` is high for exactly one clock, in the cycle after the tick that carries bit 255.
- R5: Before the first frame-sync tick after reset, no TDM bit produces output. The first sync tick sets no flag.
- R6: A frame-sync tick at any position other than bit 255 has three effects. It sets `misalign_o`, which stays set until reset. It emits no valid strobe for the broken frame. It restarts the count so that the next tick is the slot 0 MSB of a frame that is delivered correctly.
- R7: `aux_sd_o` changes only in the cycle after an `aux_bit_en_i` tick. A half period starts on a tick where `aux_lrclk_i` differs from its value at the previous tick, with the value before the first tick taken as 1. In that half, the channel MSB appears on the next tick and is followed by 31 bits, MSB first. `aux_lrclk_i` = 0 carries the left channel.
- R8: The auxiliary left channel carries all 32 bits of slot 3, and the auxiliary right channel carries all 32 bits of slot 7, from the most recently completed frame.
- R9: The auxiliary pair is captured when the left half starts. The right half then sends the slot 7 word of that same frame, even if a new frame completes during the left half.
- R10: When a frame completes on the same cycle that a left half starts, that left half and the right half after it carry the previous frame's pair. The new pair follows in the next LR period.
- R11: `dac_left_o` and `dac_right_o` keep their values in every cycle where `dac_valid_o` is low, including while the next frame is partly received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdm_bit_en_i | input | 1 | One-cycle enable: TDM bit clock rising edge |
| tdm_fs_i | input | 1 | Frame sync, sampled on TDM ticks |
| tdm_sd_i | input | 1 | TDM serial data in |
| aux_bit_en_i | input | 1 | One-cycle enable: auxiliary bit clock falling edge |
| aux_lrclk_i | input | 1 | Auxiliary LR clock level (0 = left) |
| dac_left_o | output | 72 | Three 24-bit left samples, lane g at [24g+23:24g] |
| dac_right_o | output | 72 | Three 24-bit right samples, lane g at [24g+23:24g] |
| dac_valid_o | output | 1 | One-cycle strobe when new samples are presented |
| misalign_o | output | 1 | Sticky frame-sync misalignment flag |
| aux_sd_o | output | 1 | Auxiliary I2S serial data out |

## Verification
Two events can land on the same clock edge: the completion of a TDM frame, which updates the auxiliary pair holding register, and the start of an auxiliary left half, which captures that register. The bench creates the collision by stopping the TDM stream one bit short of the frame end. It then issues the final bit and the LR clock falling transition in the same cycle. The test passes when the serialized left and right words equal the earlier frame's slot 3 and slot 7 words, and the following LR period carries the new frame. A second case completes the frame in the middle of the left half and checks that the right half does not mix frames.

// File: rtl/tdm_split_pkg.sv
package tdm_split_pkg;
  localparam int SLOT_W_DEF  = 32;
  localparam int N_PAIRS_DEF = 4;
  localparam int SMP_W_DEF   = 24;
endpackage

// File: rtl/tdm_split_rx.sv
module tdm_split_rx #(
  parameter  int SLOT_W     = 32,
  parameter  int N_SLOTS    = 8,
  localparam int FRAME_BITS = SLOT_W * N_SLOTS,
  localparam int CNT_W      = $clog2(FRAME_BITS),
  localparam int BIT_W      = $clog2(SLOT_W),
  localparam int SIDX_W     = CNT_W - BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic [SLOT_W-1:0] word_o,
  output logic              word_vld_o,
  output logic [SIDX_W-1:0] slot_o,
  output logic              frame_done_o,
  output logic              misalign_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-2:0] sh_q;
  logic              locked_q, mis_q;
  logic              last_bit, slot_end, early_fs;

  always_comb begin
    last_bit = (cnt_q == CNT_W'(FRAME_BITS - 1));
    slot_end = &cnt_q[BIT_W-1:0];
    early_fs = fs_i & ~last_bit;
  end

  assign word_o       = {sh_q, sd_i};
  assign word_vld_o   = bit_en_i & locked_q & slot_end & ~early_fs;
  assign frame_done_o = bit_en_i & locked_q & last_bit;
  assign slot_o       = cnt_q[CNT_W-1:BIT_W];
  assign misalign_o   = mis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      locked_q <= 1'b0;
      mis_q    <= 1'b0;
    end else if (bit_en_i) begin
      sh_q <= {sh_q[SLOT_W-3:0], sd_i};
      if (fs_i) begin
        cnt_q    <= '0;
        locked_q <= 1'b1;
        if (locked_q && !last_bit) mis_q <= 1'b1;
      end else if (locked_q) begin
        cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_split_buf.sv
module tdm_split_buf #(
  parameter  int SLOT_W  = 32,
  parameter  int N_PAIRS = 4,
  parameter  int SMP_W   = 24,
  localparam int N_SLOTS = 2 * N_PAIRS,
  localparam int N_INT   = N_PAIRS - 1,
  localparam int SIDX_W  = $clog2(N_SLOTS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SLOT_W-1:0]      word_i,
  input  logic                   word_vld_i,
  input  logic [SIDX_W-1:0]      slot_i,
  input  logic                   frame_done_i,
  output logic [N_INT*SMP_W-1:0] dac_left_o,
  output logic [N_INT*SMP_W-1:0] dac_right_o,
  output logic                   dac_valid_o,
  output logic [SLOT_W-1:0]      aux_left_o,
  output logic [SLOT_W-1:0]      aux_right_o
);
  logic [SLOT_W-1:0] aux_stage_q, hold_l_q, hold_r_q;
  logic              valid_q;

  for (genvar g = 0; g < N_INT; g++) begin : g_lane
    logic [SMP_W-1:0] stage_l_q, stage_r_q, out_l_q, out_r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_l_q <= '0;
        stage_r_q <= '0;
        out_l_q   <= '0;
        out_r_q   <= '0;
      end else begin
        if (word_vld_i && slot_i == SIDX_W'(g))
          stage_l_q <= word_i[SLOT_W-1 -: SMP_W];
        if (word_vld_i && slot_i == SIDX_W'(g + N_PAIRS))
          stage_r_q <= word_i[SLOT_W-1 -: SMP_W];
        if (frame_done_i) begin
          out_l_q <= stage_l_q;
          out_r_q <= stage_r_q;
        end
      end
    end
    assign dac_left_o[g*SMP_W +: SMP_W]  = out_l_q;
    assign dac_right_o[g*SMP_W +: SMP_W] = out_r_q;
  end

  // Last slot is always the word completing the frame: no stage needed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aux_stage_q <= '0;
      hold_l_q    <= '0;
      hold_r_q    <= '0;
      valid_q     <= 1'b0;
    end else begin
      if (word_vld_i && slot_i == SIDX_W'(N_PAIRS - 1)) aux_stage_q <= word_i;
      if (frame_done_i) begin
        hold_l_q <= aux_stage_q;
        hold_r_q <= word_i;
      end
      valid_q <= frame_done_i;
    end
  end

  assign dac_valid_o = valid_q;
  assign aux_left_o  = hold_l_q;
  assign aux_right_o = hold_r_q;
endmodule

// File: rtl/tdm_split_i2s_tx.sv
module tdm_split_i2s_tx #(
  parameter int SLOT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              lrclk_i,
  input  logic [SLOT_W-1:0] left_i,
  input  logic [SLOT_W-1:0] right_i,
  output logic              sd_o
);
  logic [SLOT_W-1:0] sh_q, pend_r_q;
  logic              lr_q, sd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      pend_r_q <= '0;
      lr_q     <= 1'b1;
      sd_q     <= 1'b0;
    end else if (bit_en_i) begin
      sd_q <= sh_q[SLOT_W-1];
      if (lrclk_i != lr_q) begin
        lr_q <= lrclk_i;
        if (!lrclk_i) begin
          sh_q     <= left_i;
          pend_r_q <= right_i; // pair captured together at left start
        end else begin
          sh_q <= pend_r_q;
        end
      end else begin
        sh_q <= {sh_q[SLOT_W-2:0], 1'b0};
      end
    end
  end

  assign sd_o = sd_q;
endmodule

// File: rtl/tdm_frame_splitter.sv
module tdm_frame_splitter
  import tdm_split_pkg::*;
#(
  parameter  int SLOT_W  = SLOT_W_DEF,
  parameter  int N_PAIRS = N_PAIRS_DEF,
  parameter  int SMP_W   = SMP_W_DEF,
  localparam int N_SLOTS = 2 * N_PAIRS,
  localparam int N_INT   = N_PAIRS - 1,
  localparam int SIDX_W  = $clog2(N_SLOTS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tdm_bit_en_i,
  input  logic                   tdm_fs_i,
  input  logic                   tdm_sd_i,
  input  logic                   aux_bit_en_i,
  input  logic                   aux_lrclk_i,
  output logic [N_INT*SMP_W-1:0] dac_left_o,
  output logic [N_INT*SMP_W-1:0] dac_right_o,
  output logic                   dac_valid_o,
  output logic                   misalign_o,
  output logic                   aux_sd_o
);
  logic [SLOT_W-1:0] word, aux_l, aux_r;
  logic              word_vld, frame_done;
  logic [SIDX_W-1:0] slot;

  tdm_split_rx #(.SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_rx (
    .clk_i, .rst_ni,
    .bit_en_i(tdm_bit_en_i), .fs_i(tdm_fs_i), .sd_i(tdm_sd_i),
    .word_o(word), .word_vld_o(word_vld), .slot_o(slot),
    .frame_done_o(frame_done), .misalign_o(misalign_o)
  );

  tdm_split_buf #(.SLOT_W(SLOT_W), .N_PAIRS(N_PAIRS), .SMP_W(SMP_W)) u_buf (
    .clk_i, .rst_ni,
    .word_i(word), .word_vld_i(word_vld), .slot_i(slot),
    .frame_done_i(frame_done),
    .dac_left_o(dac_left_o), .dac_right_o(dac_right_o),
    .dac_valid_o(dac_valid_o),
    .aux_left_o(aux_l), .aux_right_o(aux_r)
  );

  tdm_split_i2s_tx #(.SLOT_W(SLOT_W)) u_aux (
    .clk_i, .rst_ni,
    .bit_en_i(aux_bit_en_i), .lrclk_i(aux_lrclk_i),
    .left_i(aux_l), .right_i(aux_r), .sd_o(aux_sd_o)
  );
endmodule

// File: rtl/tdm_split_chk.sv
module tdm_split_chk #(
  parameter int W = 72
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tdm_bit_en_i,
  input logic         tdm_fs_i,
  input logic         aux_bit_en_i,
  input logic         aux_sd_o,
  input logic         dac_valid_o,
  input logic         misalign_o,
  input logic [W-1:0] dac_left_o,
  input logic [W-1:0] dac_right_o
);
  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |=> !dac_valid_o);

  p_valid_after_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_valid_o) |-> $past(tdm_bit_en_i));

  p_misalign_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> misalign_o);

  p_misalign_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(misalign_o) |-> $past(tdm_fs_i && tdm_bit_en_i));

  p_no_valid_on_misalign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(misalign_o) |-> !dac_valid_o);

  p_dac_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_valid_o |-> ($stable(dac_left_o) && $stable(dac_right_o)));

  p_aux_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_bit_en_i |=> $stable(aux_sd_o));
endmodule

bind tdm_frame_splitter tdm_split_chk #(.W((N_PAIRS - 1) * SMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tdm_bit_en_i(tdm_bit_en_i), .tdm_fs_i(tdm_fs_i),
  .aux_bit_en_i(aux_bit_en_i), .aux_sd_o(aux_sd_o),
  .dac_valid_o(dac_valid_o), .misalign_o(misalign_o),
  .dac_left_o(dac_left_o), .dac_right_o(dac_right_o)
);

// File: tb/tdm_frame_splitter_tb.sv
`timescale 1ns/1ps
module tdm_frame_splitter_tb;
  localparam int W = 72;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tdm_bit_en, tdm_fs, tdm_sd, aux_bit_en, aux_lrclk;
  logic [W-1:0] dac_left, dac_right;
  logic dac_valid, misalign, aux_sd;

  tdm_frame_splitter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tdm_bit_en_i(tdm_bit_en), .tdm_fs_i(tdm_fs), .tdm_sd_i(tdm_sd),
    .aux_bit_en_i(aux_bit_en), .aux_lrclk_i(aux_lrclk),
    .dac_left_o(dac_left), .dac_right_o(dac_right),
    .dac_valid_o(dac_valid), .misalign_o(misalign), .aux_sd_o(aux_sd)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] frm [8];
  logic lr_lvl = 1'b1;
  int vcount, vidx;

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic fill(input int seed);
    for (int s = 0; s < 8; s++) frm[s] = 32'h9E37_79B9 * (seed * 8 + s + 1) ^ 32'h0000_005A;
  endtask

  function automatic logic [95:0] exp_dac(input bit right);
    logic [95:0] r = '0;
    for (int g = 0; g < 3; g++) r[g*24 +: 24] = frm[g + (right ? 4 : 0)][31:8];
    return r;
  endfunction

  task automatic step(input logic te, input logic sd, input logic fs, input logic ae,
                      input logic lr, output logic v, output logic a);
    tdm_bit_en = te; tdm_sd = sd; tdm_fs = fs; aux_bit_en = ae; aux_lrclk = lr;
    @(posedge clk);
    @(negedge clk);
    v = dac_valid; a = aux_sd;
    tdm_bit_en = 1'b0; aux_bit_en = 1'b0; tdm_fs = 1'b0;
  endtask

  task automatic send_bits(input int lo, input int hi, input bit use_fs);
    logic v, a;
    vcount = 0; vidx = -1;
    for (int i = lo; i <= hi; i++) begin
      step(1'b1, frm[i/32][31-(i%32)], use_fs && (i == 255), 1'b0, lr_lvl, v, a);
      if (v) begin vcount++; vidx = i; end
    end
  endtask

  task automatic aux_collect(input int fin_at, output logic [31:0] l, output logic [31:0] r);
    logic a_s [66];
    logic v;
    for (int t = 0; t < 66; t++) begin
      lr_lvl = (t == 0) ? 1'b1 : (t <= 32) ? 1'b0 : (t <= 64) ? 1'b1 : 1'b0;
      step(t == fin_at, frm[7][0], t == fin_at, 1'b1, lr_lvl, v, a_s[t]);
    end
    for (int k = 0; k < 32; k++) begin
      l[31-k] = a_s[2+k];
      r[31-k] = a_s[34+k];
    end
  endtask

  task automatic t_reset();
    chk(dac_left == '0 && dac_right == '0, "R1 dac outputs zero", {dac_left, dac_right}, '0);
    chk(!dac_valid && !misalign && !aux_sd, "R1 flags zero", {dac_valid, misalign, aux_sd}, '0);
  endtask

  task automatic t_prelock();
    logic v, a;
    fill(1);
    send_bits(0, 255, 1'b0);
    chk(vcount == 0, "R5 no valid before lock", vcount, 0);
    chk(dac_left == '0, "R5 dac untouched before lock", dac_left, '0);
    step(1'b1, 1'b0, 1'b1, 1'b0, lr_lvl, v, a);
    chk(!v && !misalign, "R5 first sync no flag", {v, misalign}, '0);
  endtask

  task automatic t_frame(input int seed);
    fill(seed);
    send_bits(0, 255, 1'b1);
    chk(vcount == 1 && vidx == 255, "R4 one valid after bit 255", {vcount, vidx}, {32'd1, 32'd255});
    chk(dac_left == exp_dac(0), "R2 R3 left lanes", dac_left, exp_dac(0));
    chk(dac_right == exp_dac(1), "R2 R3 right lanes", dac_right, exp_dac(1));
  endtask

  task automatic t_hold();
    logic [95:0] el, er;
    el = exp_dac(0); er = exp_dac(1);
    fill(3);
    send_bits(0, 127, 1'b1);
    chk(vcount == 0 && !dac_valid, "R11 no valid mid frame", vcount, 0);
    chk(dac_left == el && dac_right == er, "R11 dac hold mid frame", {dac_left, dac_right}, {el, er});
    send_bits(128, 255, 1'b1);
    chk(dac_left == exp_dac(0) && dac_right == exp_dac(1), "R11 dac update on frame end",
        {dac_left, dac_right}, {exp_dac(0), exp_dac(1)});
  endtask

  task automatic t_aux();
    logic [31:0] l, r;
    aux_collect(-1, l, r);
    chk(l == frm[3], "R7 R8 aux left slot 3", l, frm[3]);
    chk(r == frm[7], "R7 R8 aux right slot 7", r, frm[7]);
  endtask

  task automatic t_coincide();
    logic [31:0] l, r, o3, o7;
    o3 = frm[3]; o7 = frm[7];
    fill(4);
    send_bits(0, 254, 1'b1);
    aux_collect(1, l, r);
    chk(l == o3 && r == o7, "R10 coincident load uses old pair", {l, r}, {o3, o7});
    chk(dac_left == exp_dac(0), "R10 frame still delivered", dac_left, exp_dac(0));
    aux_collect(-1, l, r);
    chk(l == frm[3] && r == frm[7], "R10 new pair next period", {l, r}, {frm[3], frm[7]});
  endtask

  task automatic t_pair_latch();
    logic [31:0] l, r, o3, o7;
    o3 = frm[3]; o7 = frm[7];
    fill(5);
    send_bits(0, 254, 1'b1);
    aux_collect(10, l, r);
    chk(l == o3 && r == o7, "R9 pair not torn", {l, r}, {o3, o7});
    chk(dac_right == exp_dac(1), "R9 frame delivered", dac_right, exp_dac(1));
  endtask

  task automatic t_misalign();
    logic v, a;
    fill(6);
    send_bits(0, 99, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, lr_lvl, v, a);
    chk(!v, "R6 no valid on early sync", v, 0);
    chk(misalign, "R6 flag set", misalign, 1);
    fill(7);
    send_bits(0, 255, 1'b1);
    chk(vcount == 1 && vidx == 255, "R6 realigned frame valid", {vcount, vidx}, {32'd1, 32'd255});
    chk(dac_left == exp_dac(0) && dac_right == exp_dac(1), "R6 realigned data",
        {dac_left, dac_right}, {exp_dac(0), exp_dac(1)});
    chk(misalign, "R6 flag sticky", misalign, 1);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tdm_bit_en = 1'b0; tdm_fs = 1'b0; tdm_sd = 1'b0;
    aux_bit_en = 1'b0; aux_lrclk = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prelock();
    t_frame(2);
    t_hold();
    t_aux();
    t_coincide();
    t_pair_latch();
    t_misalign();
    summary();
    $finish;
  end
endmodule